// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns an asynchronous serial line into parallel characters. A 16x oversampling enable (`tick16`) paces a state machine that finds a falling edge, confirms it at mid-bit, and then samples 5 to 8 data bits with the least significant bit first. It then samples an optional parity bit and one stop bit. Each finished character goes with a four-bit status word into a small FIFO. The consumer drains the FIFO with a valid/ready handshake.

The receiver rejects false start bits. After a framing error it waits half a bit before it searches for a new start bit. A break is reported as two separate one-cycle events, one when it starts and one when it ends, and no character is stored for it. Each character is compared with a programmed value, and a match can raise a one-cycle interrupt pulse. When the FIFO is full, a newly arriving character is dropped and the overrun status is set on the newest stored entry.

The line state machine has these states:
- `S_IDLE`: hunting for a start bit. It moves to `S_START` on a tick that sees the line low.
- `S_START`: confirming the start bit. It goes back to `S_IDLE` if the line is high at the mid-bit sample, and moves to `S_DATA` if the line is low.
- `S_DATA`: collecting data bits. After the last data bit it moves to `S_PAR` when parity is enabled, and to `S_STOP` otherwise.
- `S_PAR`: moves to `S_STOP` after one bit time.
- `S_STOP`: samples the stop bit. A high stop bit returns to `S_IDLE` and stores the character. A low stop bit with a nonzero character moves to `S_FEGAP` and stores the character. A low stop bit with an all-zero character moves to `S_BRKWAIT` and signals break start.
- `S_FEGAP`: half-bit pause. It moves to `S_IDLE` after 8 ticks.
- `S_BRKWAIT`: waiting out a break. It moves to `S_IDLE` on a tick that sees the line high, and signals break end.

Top module: `serrx_top`

## Requirements
- R1: `cfg_len` selects the character length as 5 + `cfg_len` data bits, sent least significant bit first. Unused upper bits of `rx_data` read as zero.
- R2: `cfg_parity` selects the parity mode: 0 none, 1 even, 2 odd, 3 forced to `cfg_par_val`. When the received parity bit differs from the expected one, `rx_stat[1]` is set.
- R3: A stop bit sampled low on a character with at least one 1 among its data and parity bits stores that character with `rx_stat[2]` (framing) set.
- R4: A start bit that is high again at its mid-bit sample, 8 ticks after detection, is discarded. No character and no event results.
- R5: After a framing error, start-bit search resumes only 8 ticks after the stop sample. A line still low through the rest of the stop bit and 4 more ticks does not produce a character.
- R6: A character whose data, parity and stop positions are all zero is a break. It raises `brk_start` for exactly one cycle and stores nothing. `brk_end` pulses once on the first tick that sees the line high again.
- R7: `rx_stat[0]` is set when the received data equals `cfg_cmp` masked to the character length. When `cfg_cmp_ie` is 1, a match also pulses `cmp_irq` for one cycle.
- R8: Up to DEPTH (4) characters are buffered in arrival order. `rx_valid` and `rx_data` hold steady while `rx_ready` is low.
- R9: A character that completes while the FIFO is full is dropped, and `rx_stat[3]` (overrun) is set on the newest stored entry.
- R10: After reset, `rx_valid`, `brk_start`, `brk_end` and `cmp_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_parity | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced |
| cfg_par_val | input | 1 | Parity value expected in forced mode |
| cfg_cmp | input | DW | Compare value |
| cfg_cmp_ie | input | 1 | Enables the match interrupt pulse |
| rx_valid | output | 1 | FIFO head is valid |
| rx_ready | input | 1 | Consumer takes the FIFO head |
| rx_data | output | DW | Received character |
| rx_stat | output | 4 | {overrun, framing, parity, match} |
| brk_start | output | 1 | Break start event, one cycle |
| brk_end | output | 1 | Break end event, one cycle |
| cmp_irq | output | 1 | Compare match interrupt pulse |

## Verification
The bench builds the block with its defaults: DEPTH of 4 and DW of 8. A fifth character sent while `rx_ready` is held low therefore exercises the overrun path, and every length from 5 to 8 bits fits the data port. The oversampling enable arrives every second clock, so each state's tick counter and the half-bit framing gap are exercised at a real rate. The framing-gap case is placed so that a receiver without the gap would confirm a start bit. Break, false start and compare are checked through event pulses and through an empty FIFO.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int RX_OSR = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_FEGAP,
        S_BRKWAIT
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_FORCE = 2'd3
    } par_mode_t;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
        logic match;
    } rx_stat_t;

endpackage

// File: rtl/serrx_frame.sv
module serrx_frame
    import serrx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_parity,
    input  logic          cfg_par_val,
    input  logic [DW-1:0] cfg_cmp,
    output logic          char_vld,
    output logic [DW-1:0] char_data,
    output rx_stat_t      char_stat,
    output logic          brk_start,
    output logic          brk_end
);
    localparam int CW = $clog2(RX_OSR);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(RX_OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(RX_OSR - 1);

    rx_state_t     state_q, state_d;
    logic [1:0]    sync_q;
    logic          rx_s;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] bit_q;
    logic [DW-1:0] data_q;
    logic          par_q;
    logic          anyone_q;
    logic [BW:0]   nbits;
    logic [DW-1:0] mask;
    logic          par_en;
    logic          exp_par;
    logic          at_mid;
    logic          at_last;
    logic          stop_ev;

    assign rx_s    = sync_q[1];
    assign nbits   = (BW+1)'(5) + (BW+1)'(cfg_len);
    assign mask    = ~({DW{1'b1}} << nbits);
    assign par_en  = (cfg_parity != PAR_NONE);
    assign at_mid  = tick && (cnt_q == MID);
    assign at_last = tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (tick && !rx_s) state_d = S_START;
            S_START:   if (at_mid) state_d = rx_s ? S_IDLE : S_DATA;
            S_DATA:    if (at_last && (bit_q == BW'(nbits - 1'b1)))
                           state_d = par_en ? S_PAR : S_STOP;
            S_PAR:     if (at_last) state_d = S_STOP;
            S_STOP:    if (at_last) begin
                           if (rx_s)          state_d = S_IDLE;
                           else if (anyone_q) state_d = S_FEGAP;
                           else               state_d = S_BRKWAIT;
                       end
            S_FEGAP:   if (at_mid) state_d = S_IDLE;
            S_BRKWAIT: if (tick && rx_s) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // counters and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bit_q    <= '0;
            data_q   <= '0;
            par_q    <= 1'b0;
            anyone_q <= 1'b0;
        end else if (tick) begin
            if (state_d != state_q) cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
            if (state_q == S_START) begin
                data_q   <= '0;
                bit_q    <= '0;
                anyone_q <= 1'b0;
            end
            if (state_q == S_DATA && cnt_q == LAST) begin
                data_q[bit_q] <= rx_s;
                bit_q         <= bit_q + 1'b1;
                if (rx_s) anyone_q <= 1'b1;
            end
            if (state_q == S_PAR && cnt_q == LAST) begin
                par_q <= rx_s;
                if (rx_s) anyone_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (cfg_parity)
            PAR_EVEN:  exp_par = ^data_q;
            PAR_ODD:   exp_par = ~^data_q;
            PAR_FORCE: exp_par = cfg_par_val;
            default:   exp_par = 1'b0;
        endcase
    end

    // outputs
    always_comb begin
        stop_ev         = (state_q == S_STOP) && at_last;
        char_vld        = stop_ev && (rx_s || anyone_q);
        brk_start       = stop_ev && !rx_s && !anyone_q;
        brk_end         = (state_q == S_BRKWAIT) && tick && rx_s;
        char_data       = data_q;
        char_stat.ovr   = 1'b0;
        char_stat.frm   = !rx_s;
        char_stat.par   = par_en && (par_q != exp_par);
        char_stat.match = (data_q == (cfg_cmp & mask));
    end

    // R4
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && at_mid && rx_s) |=> (state_q == S_IDLE && !char_vld));

    // R5
    fe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && char_stat.frm) |=> (state_q == S_FEGAP));

    // R6
    brk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_start |=> (state_q == S_BRKWAIT && !brk_start));

    // R6
    brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> (state_q == S_IDLE && !brk_end));

endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   count_q;
    logic          full, pop_ok, push_ok, drop;

    assign full    = (count_q == (AW+1)'(DEPTH));
    assign valid   = (count_q != '0);
    assign pop_ok  = pop && valid;
    assign push_ok = push && (!full || pop_ok);
    assign drop    = push && full && !pop_ok;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push_ok)   mem[wr_q] <= din;
        else if (drop) mem[wr_q - AW'(1)][W-1] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (pop_ok)  rd_q <= rd_q + 1'b1;
            if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
            else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
        end
    end

    // R9
    ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (count_q == $past(count_q) && valid));

endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_parity,
    input  logic          cfg_par_val,
    input  logic [DW-1:0] cfg_cmp,
    input  logic          cfg_cmp_ie,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic [DW-1:0] rx_data,
    output logic [3:0]    rx_stat,
    output logic          brk_start,
    output logic          brk_end,
    output logic          cmp_irq
);
    localparam int SW = $bits(rx_stat_t);
    localparam int W  = DW + SW;

    logic          char_vld;
    logic [DW-1:0] char_data;
    rx_stat_t      char_stat;
    logic [W-1:0]  head;
    logic          irq_q;

    serrx_frame #(.DW(DW)) frame_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_par_val(cfg_par_val),
        .cfg_cmp(cfg_cmp), .char_vld(char_vld), .char_data(char_data),
        .char_stat(char_stat), .brk_start(brk_start), .brk_end(brk_end)
    );

    serrx_fifo #(.DEPTH(DEPTH), .W(W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(char_vld), .din({char_stat, char_data}),
        .pop(rx_ready), .valid(rx_valid), .dout(head)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= char_vld && char_stat.match && cfg_cmp_ie;
    end

    assign cmp_irq = irq_q;
    assign rx_data = head[DW-1:0];
    assign rx_stat = head[W-1:DW];

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_stat[2:0])));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> $past(char_vld && cfg_cmp_ie));

endmodule

// File: tb/serrx_tb.sv
`timescale 1ns/1ps
module serrx_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdiv = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_par_val = 1'b0;
    logic [7:0] cfg_cmp = 8'h00;
    logic       cfg_cmp_ie = 1'b0;
    logic       rx_ready = 1'b1;
    logic       rx_valid, brk_start, brk_end, cmp_irq;
    logic [7:0] rx_data;
    logic [3:0] rx_stat;

    int total = 0, bad = 0;
    int n_brk_s = 0, n_brk_e = 0, n_irq = 0;
    logic [11:0] sb_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) tdiv <= ~tdiv;

    serrx_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tdiv), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_par_val(cfg_par_val),
        .cfg_cmp(cfg_cmp), .cfg_cmp_ie(cfg_cmp_ie), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_stat(rx_stat),
        .brk_start(brk_start), .brk_end(brk_end), .cmp_irq(cmp_irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pop and event counters
    always @(negedge clk) begin
        if (rst_n) begin
            if (brk_start) n_brk_s++;
            if (brk_end)   n_brk_e++;
            if (cmp_irq)   n_irq++;
            if (rx_valid && rx_ready) begin
                if (sb_q.size() == 0) chk(0, "R8 unexpected character", {rx_stat, rx_data}, 0);
                else begin
                    logic [11:0] e;
                    string t;
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    chk({rx_stat, rx_data} == e, t, {rx_stat, rx_data}, e);
                end
            end
        end
    end

    task automatic one_tick();
        @(negedge clk);
        while (!tdiv) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic line(input logic v, input int ticks);
        @(negedge clk);
        rxd = v;
        for (int i = 0; i < ticks; i++) one_tick();
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk);
        #2 rx_ready = v;
    endtask

    // driver: one character frame, expected item pushed into scoreboard
    task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v,
                        input int extra_low, input bit expect_item, input string tag);
        int n;
        logic [7:0] m;
        logic p;
        n = 5 + cfg_len;
        m = 8'hFF >> (8 - n);
        unique case (cfg_parity)
            2'd1: p = ^(d & m);
            2'd2: p = ~^(d & m);
            2'd3: p = cfg_par_val;
            default: p = 1'b0;
        endcase
        p = p ^ bad_par;
        if (expect_item) begin
            sb_q.push_back({1'b0, !stop_v, (cfg_parity != 2'd0) && bad_par,
                            ((d & m) == (cfg_cmp & m)), d & m});
            tag_q.push_back(tag);
        end
        line(1'b0, 16);
        for (int i = 0; i < n; i++) line(d[i], 16);
        if (cfg_parity != 2'd0) line(p, 16);
        line(stop_v, 16);
        if (extra_low > 0) line(1'b0, extra_low);
        line(1'b1, 24);
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 3000 && (sb_q.size() != 0 || rx_valid); i++) @(negedge clk);
        chk(sb_q.size() == 0, tag, sb_q.size(), 0);
        chk(!rx_valid, tag, rx_valid, 0);
    endtask

    initial begin
        #(20 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset values
        chk(!rx_valid && !brk_start && !brk_end && !cmp_irq, "R10 reset outputs",
            {rx_valid, brk_start, brk_end, cmp_irq}, 0);
        rst_n = 1'b1;
        line(1'b1, 20);
        chk(!rx_valid, "R10 idle after reset", rx_valid, 0);

        // R1 lengths
        send(8'hA5, 0, 1, 0, 1, "R1 len8 A5");
        send(8'h3C, 0, 1, 0, 1, "R1 len8 3C");
        cfg_len = 2'd0;
        send(8'hFB, 0, 1, 0, 1, "R1 len5");
        cfg_len = 2'd1;
        send(8'hEA, 0, 1, 0, 1, "R1 len6");
        cfg_len = 2'd2;
        send(8'hD5, 0, 1, 0, 1, "R1 len7");
        cfg_len = 2'd3;
        drain("R1 drained");

        // R2 parity modes
        cfg_parity = 2'd1;
        send(8'h37, 0, 1, 0, 1, "R2 even ok");
        send(8'h37, 1, 1, 0, 1, "R2 even bad");
        cfg_parity = 2'd2;
        send(8'h81, 0, 1, 0, 1, "R2 odd ok");
        send(8'h80, 1, 1, 0, 1, "R2 odd bad");
        cfg_parity = 2'd3; cfg_par_val = 1'b1;
        send(8'h11, 0, 1, 0, 1, "R2 force1 ok");
        send(8'h11, 1, 1, 0, 1, "R2 force1 bad");
        cfg_par_val = 1'b0;
        send(8'h22, 1, 1, 0, 1, "R2 force0 bad");
        cfg_parity = 2'd0;
        drain("R2 drained");

        // R3 framing error
        send(8'h6E, 0, 0, 0, 1, "R3 framing");
        drain("R3 drained");

        // R4 false start
        line(1'b0, 4);
        line(1'b1, 40);
        drain("R4 no character from glitch");
        chk(n_brk_s == 0 && n_brk_e == 0, "R4 no events", n_brk_s + n_brk_e, 0);

        // R5 half-bit gap after framing error
        send(8'h5D, 0, 0, 4, 1, "R5 framing before gap");
        drain("R5 no character in gap");
        send(8'h42, 0, 1, 0, 1, "R5 char after gap");
        drain("R5 drained");

        // R6 break
        send(8'h00, 0, 0, 48, 0, "R6 break");
        chk(n_brk_s == 1, "R6 single break start", n_brk_s, 1);
        chk(n_brk_e == 1, "R6 break end once", n_brk_e, 1);
        drain("R6 break stores nothing");
        cfg_parity = 2'd1;
        line(1'b0, 16 * 11);
        chk(n_brk_s == 2 && n_brk_e == 1, "R6 held low with parity", n_brk_s * 16 + n_brk_e, 8'h21);
        line(1'b1, 24);
        chk(n_brk_e == 2, "R6 end after release", n_brk_e, 2);
        cfg_parity = 2'd0;

        // R7 compare
        chk(n_irq == 0, "R7 no irq while disabled", n_irq, 0);
        cfg_cmp = 8'h5A; cfg_cmp_ie = 1'b1;
        send(8'h5A, 0, 1, 0, 1, "R7 match");
        send(8'h5B, 0, 1, 0, 1, "R7 no match");
        chk(n_irq == 1, "R7 one irq", n_irq, 1);
        cfg_len = 2'd0; cfg_cmp = 8'hFA;
        send(8'h1A, 0, 1, 0, 1, "R7 masked match");
        chk(n_irq == 2, "R7 masked irq", n_irq, 2);
        cfg_len = 2'd3; cfg_cmp_ie = 1'b0; cfg_cmp = 8'h00;
        drain("R7 drained");

        // R8 buffering with consumer stalled
        set_ready(1'b0);
        send(8'h01, 0, 1, 0, 1, "R8 fifo 0");
        send(8'h02, 0, 1, 0, 1, "R8 fifo 1");
        send(8'h03, 0, 1, 0, 1, "R8 fifo 2");
        send(8'h04, 0, 1, 0, 1, "R8 fifo 3");
        @(negedge clk);
        chk(rx_valid && rx_data == 8'h01, "R8 head held", rx_data, 8'h01);
        set_ready(1'b1);
        drain("R8 drained");

        // R9 overrun
        set_ready(1'b0);
        send(8'h71, 0, 1, 0, 1, "R9 entry 0");
        send(8'h72, 0, 1, 0, 1, "R9 entry 1");
        send(8'h73, 0, 1, 0, 1, "R9 entry 2");
        send(8'h74, 0, 1, 0, 1, "R9 entry 3 flagged");
        send(8'h75, 0, 1, 0, 0, "R9 dropped");
        sb_q[3][11] = 1'b1;
        set_ready(1'b1);
        drain("R9 drained");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule